// File: doc/BRIEF.md
# Stream to Acknowledge-Style Transmit Adapter

This block connects a byte-wide ready/valid stream source to a MAC transmit port that uses the older acknowledge handshake. On that port, the first byte of a frame is offered and held until the MAC acknowledges it. After the acknowledge, the MAC takes one byte on every enabled cycle until the valid line drops. There is no frame buffer in between. The adapter therefore converts the handshake in both directions. When the source cannot keep up, it raises an underrun instead of waiting.

Errors can reach the MAC in two ways. In the implicit case, the stream's valid is low on an enabled cycle in the middle of a frame. In the explicit case, the source marks a byte with its user flag. Either case becomes a one-enabled-cycle underrun pulse, and the rest of the frame is drained from the stream and discarded. A clock-enable input sets the byte rate for the slower line speeds. Every handshake and every output update happens only on cycles where the enable is high.

Top module: `strm2ack_tx`

## Requirements
- R1: While reset is low, and after it is released, txValid and txUnderrun are 0.
- R2: In idle, sReady equals clkEn. A byte taken on an enabled cycle with sValid high appears on txData with txValid = 1 after that clock edge.
- R3: While the first byte waits for its acknowledge, sReady is 0 and txData and txValid keep their values.
- R4: txAck counts only on a cycle with clkEn = 1. On that cycle sReady is 1, unless the first byte carried sLast or sUser, and the byte taken appears on txData after that edge.
- R5: After the acknowledge, sReady equals clkEn and each byte taken appears on txData after its edge. On cycles with clkEn = 0 no output changes.
- R6: txValid drops at the enabled edge after the sLast byte has been presented. For a one-byte frame it drops at the acknowledge edge.
- R7: In the streaming phase, sValid = 0 on an enabled cycle sets txUnderrun = 1 and txValid = 0 after that edge.
- R8: A byte taken after the acknowledge with sUser = 1 is not forwarded: txUnderrun goes to 1 and txValid to 0. If the first byte carried sUser = 1, the same happens at the acknowledge edge.
- R9: txUnderrun stays high for exactly one enabled cycle. It is held across disabled cycles and cleared at the next enabled edge.
- R10: After an underrun, sReady equals clkEn and the bytes taken are discarded with txValid low, up to and including the sLast byte. Then the block returns to idle. If the errored byte itself carried sLast, the block goes to idle at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Byte-rate enable; all transfers happen on cycles with it high |
| sData | input | DATA_W | Stream byte |
| sValid | input | 1 | Stream byte valid |
| sReady | output | 1 | Adapter takes the stream byte this cycle |
| sLast | input | 1 | Marks the last byte of a frame |
| sUser | input | 1 | Forces an error on the frame when set with a byte |
| txData | output | DATA_W | Byte to the MAC |
| txValid | output | 1 | Frame in progress on the MAC side |
| txAck | input | 1 | MAC acknowledges the first byte |
| txUnderrun | output | 1 | Error pulse that corrupts the current frame |

## Verification
A wrong phase in the control shows up within one enabled cycle in two places: the combinational sReady and the next txValid. For example, a missed acknowledge leaves sReady low when it should rise. A wrong drain exit lets a discarded byte reach txData with txValid high. A stale first-byte error or last flag only shows at the acknowledge edge, so frames that have an acknowledge delay are paired with every error position. The reference model checks txData, txValid and txUnderrun at every cycle and sReady after each input change. Any divergence is therefore reported in the cycle it first becomes visible.

// File: rtl/txadapt_pkg.sv
package txadapt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SEND  = 3'd2,
    ST_TAIL  = 3'd3,
    ST_DRAIN = 3'd4
  } phase_e;

  // Strobes from control to datapath, acted on only when clkEn is high
  typedef struct packed {
    logic load;
    logic setValid;
    logic clrValid;
    logic raiseErr;
  } strobe_t;

endpackage

// File: rtl/txadapt_ctrl.sv
module txadapt_ctrl
  import txadapt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clkEn,
  input  logic    sValid,
  input  logic    sLast,
  input  logic    sUser,
  input  logic    txAck,
  output logic    sReady,
  output strobe_t stb
);

  phase_e  state, nxt;
  logic    firstErr, firstLast;
  strobe_t takeStb;
  phase_e  takeNxt;

  // Outcome of taking one byte after the acknowledge
  always_comb begin
    takeStb = '0;
    takeNxt = ST_SEND;
    if (!sValid) begin
      takeStb.clrValid = 1'b1;
      takeStb.raiseErr = 1'b1;
      takeNxt          = ST_DRAIN;
    end else if (sUser) begin
      takeStb.clrValid = 1'b1;
      takeStb.raiseErr = 1'b1;
      takeNxt          = sLast ? ST_IDLE : ST_DRAIN;
    end else begin
      takeStb.load = 1'b1;
      takeNxt      = sLast ? ST_TAIL : ST_SEND;
    end
  end

  always_comb begin
    nxt    = state;
    stb    = '0;
    sReady = 1'b0;
    unique case (state)
      ST_IDLE: begin
        sReady = clkEn;
        if (clkEn && sValid) begin
          stb.load     = 1'b1;
          stb.setValid = 1'b1;
          nxt          = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (clkEn && txAck) begin
          if (firstErr) begin
            stb.clrValid = 1'b1;
            stb.raiseErr = 1'b1;
            nxt          = firstLast ? ST_IDLE : ST_DRAIN;
          end else if (firstLast) begin
            stb.clrValid = 1'b1;
            nxt          = ST_IDLE;
          end else begin
            sReady = 1'b1;
            stb    = takeStb;
            nxt    = takeNxt;
          end
        end
      end
      ST_SEND: begin
        sReady = clkEn;
        if (clkEn) begin
          stb = takeStb;
          nxt = takeNxt;
        end
      end
      ST_TAIL: begin
        if (clkEn) begin
          stb.clrValid = 1'b1;
          nxt          = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        sReady = clkEn;
        if (clkEn && sValid && sLast) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstErr  <= 1'b0;
      firstLast <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && clkEn && sValid) begin
        firstErr  <= sUser;
        firstLast <= sLast;
      end
    end
  end

endmodule

// File: rtl/txadapt_dpath.sv
module txadapt_dpath
  import txadapt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] sData,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  output logic              txUnderrun
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData     <= '0;
      txValid    <= 1'b0;
      txUnderrun <= 1'b0;
    end else if (clkEn) begin
      txUnderrun <= stb.raiseErr;
      if (stb.load) txData <= sData;
      if (stb.setValid)      txValid <= 1'b1;
      else if (stb.clrValid) txValid <= 1'b0;
    end
  end

endmodule

// File: rtl/strm2ack_tx.sv
module strm2ack_tx
  import txadapt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [DATA_W-1:0] sData,
  input  logic              sValid,
  output logic              sReady,
  input  logic              sLast,
  input  logic              sUser,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txAck,
  output logic              txUnderrun
);

  strobe_t stb;

  txadapt_ctrl ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .sValid(sValid), .sLast(sLast),
    .sUser(sUser), .txAck(txAck), .sReady(sReady), .stb(stb)
  );

  txadapt_dpath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .stb(stb), .sData(sData),
    .txData(txData), .txValid(txValid), .txUnderrun(txUnderrun)
  );

endmodule

// File: rtl/strm2ack_tx_chk.sv
module strm2ack_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              sReady,
  input logic [DATA_W-1:0] txData,
  input logic              txValid,
  input logic              txUnderrun
);

  // R9
  underrun_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txUnderrun && clkEn) |=> !txUnderrun);

  // R7
  underrun_kills_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |-> !txValid);

  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(txData) && $stable(txValid) && $stable(txUnderrun)));

  // R2
  ready_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> clkEn);

endmodule

bind strm2ack_tx strm2ack_tx_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .sReady(sReady),
  .txData(txData), .txValid(txValid), .txUnderrun(txUnderrun)
);

// File: tb/strm2ack_tx_test.sv
module strm2ack_tx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic [7:0] sData = '0;
  logic       sValid = 1'b0, sLast = 1'b0, sUser = 1'b0, txAck = 1'b0;
  logic       sReady, txValid, txUnderrun;
  logic [7:0] txData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model: phase 0 idle, 1 awaiting ack, 2 sending, 3 ending, 4 discarding
  int         ph = 0;
  bit         mVal = 0, mUnd = 0, pErr = 0, pLast = 0;
  logic [7:0] mData = '0;
  string      tag = "R1", undTag = "R1";

  always #5 clk = ~clk;

  strm2ack_tx #(.DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .sData(sData), .sValid(sValid),
    .sReady(sReady), .sLast(sLast), .sUser(sUser), .txData(txData),
    .txValid(txValid), .txAck(txAck), .txUnderrun(txUnderrun)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit expReady(input bit en, input bit ack);
    case (ph)
      0, 2, 4: return en;
      1:       return en && ack && !pLast && !pErr;
      default: return 1'b0;
    endcase
  endfunction

  task automatic takeByte(input bit val, input bit last, input bit user, input logic [7:0] d);
    if (!val) begin
      mVal = 0; mUnd = 1; ph = 4; tag = "R7"; undTag = "R7";
    end else if (user) begin
      mVal = 0; mUnd = 1; ph = last ? 0 : 4; tag = "R8"; undTag = "R8";
    end else begin
      mData = d; ph = last ? 3 : 2; tag = (ph == 3) ? "R6" : "R5";
    end
  endtask

  task automatic modelStep(input bit en, input bit val, input bit last, input bit user,
                           input logic [7:0] d, input bit ack);
    if (!en) begin
      tag = "R5"; undTag = mUnd ? "R9" : "R5";
      return;
    end
    undTag = mUnd ? "R9" : "R9";
    mUnd = 0;
    case (ph)
      0: begin
        tag = "R2";
        if (val) begin mData = d; mVal = 1; pErr = user; pLast = last; ph = 1; end
      end
      1: begin
        if (!ack) tag = "R3";
        else if (pErr) begin
          mVal = 0; mUnd = 1; ph = pLast ? 0 : 4; tag = "R8"; undTag = "R8";
        end else if (pLast) begin
          mVal = 0; ph = 0; tag = "R6";
        end else begin
          takeByte(val, last, user, d);
          if (val && !user) tag = "R4";
        end
      end
      2: takeByte(val, last, user, d);
      3: begin mVal = 0; ph = 0; tag = "R6"; end
      default: begin
        tag = "R10";
        if (val && last) ph = 0;
      end
    endcase
  endtask

  // One clock: compare outputs, drive inputs, compare ready, advance the model
  task automatic step(input bit en, input bit val, input bit last, input bit user,
                      input logic [7:0] d, input bit ack, output bit acc);
    @(negedge clk);
    cyc++;
    check(tag, "txValid", int'(txValid), int'(mVal));
    check(undTag, "txUnderrun", int'(txUnderrun), int'(mUnd));
    if (mVal) check(tag, "txData", int'(txData), int'(mData));
    clkEn = en; sValid = val; sLast = last; sUser = user; sData = d; txAck = ack;
    #1;
    check((ph == 1) ? "R3" : (ph == 4) ? "R10" : "R2", "sReady",
          int'(sReady), int'(expReady(en, ack)));
    acc = sReady && val;
    modelStep(en, val, last, user, d, ack);
  endtask

  // Source and MAC behaviour for one frame
  task automatic runFrame(input int len, input int base, input int ackDelay, input int enDiv,
                          input int gapAt, input int gapLen, input int userAt);
    int  idx = 0;
    int  gapLeft = gapLen;
    int  waitCnt = 0;
    bit  acked = 0;
    int  guard = 0;
    bit  acc;
    while (idx < len && guard < 3000) begin
      bit en  = ((cyc % enDiv) == 0);
      bit val = 1;
      bit ack;
      if (idx == gapAt && gapLeft > 0) begin val = 0; gapLeft--; end
      if (!txValid) begin acked = 0; waitCnt = 0; end
      ack = txValid && !acked && (waitCnt >= ackDelay);
      if (txValid && !acked) waitCnt++;
      step(en, val, (idx == len - 1), (idx == userAt), 8'(base + idx), ack, acc);
      if (ack && en) acked = 1;
      if (acc) idx++;
      guard++;
    end
    for (int k = 0; k < 6 * enDiv + 2; k++) begin
      bit ack = txValid && !acked && (waitCnt >= ackDelay);
      if (txValid && !acked) waitCnt++;
      if (!txValid) begin acked = 0; waitCnt = 0; end
      step((cyc % enDiv) == 0, 0, 0, 0, 8'h00, ack, acc);
      if (ack && ((cyc - 1) % enDiv) == 0) acked = 1;
    end
  endtask

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", "txValid in reset", int'(txValid), 0);
    check("R1", "txUnderrun in reset", int'(txUnderrun), 0);
    rstN = 1'b1;
    step(1, 0, 0, 0, 8'h00, 0, acc);
    check("R1", "txValid after reset", int'(txValid), 0);

    runFrame(5, 8'h10, 3, 1, -1, 0, -1);   // R2 R3 R4 plain frame
    runFrame(4, 8'h20, 2, 3, -1, 0, -1);   // R5 throttled
    runFrame(1, 8'h30, 1, 1, -1, 0, -1);   // R6 single byte
    runFrame(6, 8'h40, 0, 1, 3, 2, -1);    // R7 implicit, R10 drain
    runFrame(6, 8'h50, 2, 2, 2, 3, -1);    // R7 throttled
    runFrame(5, 8'h60, 1, 1, -1, 0, 2);    // R8 explicit mid frame
    runFrame(4, 8'h70, 2, 1, -1, 0, 0);    // R8 error on first byte
    runFrame(4, 8'h80, 1, 1, -1, 0, 3);    // R10 error on last byte
    runFrame(1, 8'h90, 2, 2, -1, 0, 0);    // R8 single errored byte
    runFrame(2, 8'hA0, 0, 1, 1, 1, -1);    // R7 gap on last byte

    for (int f = 0; f < 250; f++) begin
      int len = 1 + int'($urandom % 8);
      int gp  = (($urandom % 4) == 0) ? int'($urandom % len) : -1;
      int us  = (($urandom % 5) == 0) ? int'($urandom % len) : -1;
      runFrame(len, int'($urandom % 256), int'($urandom % 4), 1 + int'($urandom % 3),
               gp, 1 + int'($urandom % 3), us);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule